// File: doc/BRIEF.md
# Token-Gated Fixed-Priority Bus Arbiter

This block decides which of five internal requesters may use a shared memory bus. Each requester has one request line and one grant line. The requesters, from most to least urgent, are:

1. the receive DMA engine
2. the host processor port
3. the transmit DMA engine
4. the interrupt controller
5. the DRAM refresh sequencer

Local arbitration is gated by ownership of a token. The token circulates among several identical chips that share the same memory. The chips are wired in a ring: each chip's token output feeds the next chip's token input.

A chip may issue grants only while it holds the token. It gains the token when a rising edge on its token input has passed through a synchronizer. When it has no more pending work, it gives the token away by driving a pulse of fixed length on its token output. A strap input decides whether a chip starts as the owner, so exactly one chip in the ring begins with the token.

Top module: `bus_token_arbiter`

## Requirements
- R1: While reset is asserted, `grant` is 0 and `tok_out` is 0. After reset, a chip whose `start_owner` strap is 0 issues no grant for any request until it receives the token.
- R2: Requester index 0 has the highest priority and index 4 the lowest. Index 0 is receive DMA, 1 is processor, 2 is transmit DMA, 3 is interrupt and 4 is refresh. The new grant is the lowest-indexed active request. `grant[i]` is asserted one clock edge after the decision is taken.
- R3: A grant stays on its requester for as long as that requester's request stays high, even if a higher-priority request arrives.
- R4: When the granted requester drops its request, the grant moves on the same clock edge to the highest-priority request still pending. No idle cycle is inserted.
- R5: At most one bit of `grant` is high in any cycle.
- R6: While the chip does not hold the token, `grant` stays 0 whatever the request lines do. This includes the whole time the token pulse is being driven.
- R7: A rising edge on `tok_in` makes the chip the token owner. With the default two synchronizer stages, if `tok_in` rises before clock edge k, ownership begins at edge k+2. A pending request is then granted at edge k+3.
- R8: If the chip holds the token and the next grant would be empty, the token is released at the next clock edge. `grant` goes to 0 and `tok_out` goes high for exactly PULSE_CYCLES cycles (default 3), then returns to 0.
- R9: A `tok_in` that stays high does not capture the token again. Only a rising edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_owner | input | 1 | Strap: 1 means this chip holds the token after reset |
| req | input | N_REQ (5) | Request lines; index 0 has the highest priority |
| grant | output | N_REQ (5) | Registered one-hot grant lines |
| tok_in | input | 1 | Token input from the previous chip in the ring (asynchronous) |
| tok_out | output | 1 | Token pulse output to the next chip in the ring |

## Verification
Several properties are checked on every cycle:
- the grant is never more than one-hot;
- no grant appears while the token is not held or while the pulse is on `tok_out`;
- a grant persists while its request stays high;
- an owner with no requests always moves to the pulse;
- a synchronized rising edge always leads to ownership.

Other behaviour can only be shown by the bench's scenarios. These are the exact cycle on which a captured token turns into a grant, the priority order among the different request mixes, the exact pulse length, and the fact that a steady-high token input does not recapture the token.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    TK_IDLE = 2'd0,
    TK_HOLD = 2'd1,
    TK_PASS = 2'd2
  } tok_state_e;

  // Next grant: keep the current owner if it still requests, else take the pick.
  function automatic logic [4:0] next_grant5(input logic [4:0] cur,
                                             input logic [4:0] req,
                                             input logic [4:0] pick);
    return (|(cur & req)) ? cur : pick;
  endfunction

endpackage

// File: rtl/tok_sync.sv
module tok_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_in,
  output logic tok_rise
);
  logic [STAGES-1:0] shf;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf  <= '0;
      last <= 1'b0;
    end else begin
      shf  <= {shf[STAGES-2:0], tok_in};
      last <= shf[STAGES-1];
    end
  end

  assign tok_rise = shf[STAGES-1] & ~last;
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  logic [N-1:0] seen;

  assign seen[0] = 1'b0;
  assign pick[0] = req[0];

  genvar i;
  generate
    for (i = 1; i < N; i++) begin : g_chain
      assign seen[i] = seen[i-1] | req[i-1];
      assign pick[i] = req[i] & ~seen[i];
    end
  endgenerate
endmodule

// File: rtl/token_fsm.sv
module token_fsm
  import arb_pkg::*;
#(
  parameter int PULSE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_owner,
  input  logic tok_rise,
  input  logic work_left,
  output logic holding,
  output logic tok_out
);
  localparam int CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

  tok_state_e     state;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= start_owner ? TK_HOLD : TK_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        TK_IDLE: if (tok_rise) state <= TK_HOLD;
        TK_HOLD: if (!work_left) begin
          state <= TK_PASS;
          cnt   <= LOAD;
        end
        TK_PASS: begin
          if (cnt == '0) state <= TK_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= TK_IDLE;
      endcase
    end
  end

  assign holding = (state == TK_HOLD);
  assign tok_out = (state == TK_PASS);

  // R7: a synchronized edge seen while idle always yields ownership
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TK_IDLE && tok_rise) |=> holding);

  // R8: a pulse only ever starts from the owning state
  p_pass_from_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tok_out) |-> $past(holding));
endmodule

// File: rtl/bus_token_arbiter.sv
module bus_token_arbiter
  import arb_pkg::*;
#(
  parameter int N_REQ        = 5,
  parameter int PULSE_CYCLES = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_owner,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant,
  input  logic             tok_in,
  output logic             tok_out
);
  logic             tok_rise;
  logic             holding;
  logic             work_left;
  logic             keep_cur;
  logic [N_REQ-1:0] pick;
  logic [N_REQ-1:0] cand;

  tok_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_in   (tok_in),
    .tok_rise (tok_rise)
  );

  prio_pick #(.N(N_REQ)) u_pick (
    .req  (req),
    .pick (pick)
  );

  token_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_owner (start_owner),
    .tok_rise    (tok_rise),
    .work_left   (work_left),
    .holding     (holding),
    .tok_out     (tok_out)
  );

  assign keep_cur  = |(grant & req);
  assign cand      = keep_cur ? grant : pick;
  assign work_left = |cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant <= '0;
    else        grant <= holding ? cand : '0;
  end

  // R5: never more than one grant
  p_onehot_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6: no grant unless the token is owned
  p_no_grant_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !holding |-> (grant == '0));

  // R3: a grant persists while its request stays high
  p_hold_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && keep_cur) |=> (grant == $past(grant)));

  // R8: an owner with nothing to do hands the token on
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && req == '0) |=> tok_out);

  // R8: the token pulse and a grant never overlap
  p_quiet_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> (grant == '0));
endmodule

// File: tb/tb_bus_token_arbiter.sv
module tb_bus_token_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_owner = 1'b1;
  logic [4:0] req = 5'b00110;
  logic [4:0] grant;
  logic       tok_in = 1'b0;
  logic       tok_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] g;
    logic       t;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  bus_token_arbiter dut (
    .clk(clk), .rst_n(rst_n), .start_owner(start_owner),
    .req(req), .grant(grant), .tok_in(tok_in), .tok_out(tok_out)
  );

  // Driver: apply inputs after a falling edge, push expected outputs after the next rise
  task automatic step(input logic [4:0] r, input logic ti,
                      input logic [4:0] eg, input logic et, input string tag);
    exp_t e;
    @(negedge clk);
    req = r;
    tok_in = ti;
    e.g = eg;
    e.t = et;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic direct(input logic [4:0] eg, input logic et, input string tag);
    checks++;
    if (grant !== eg || tok_out !== et) begin
      errors++;
      $display("FAIL %s: grant=%b tok_out=%b expected grant=%b tok_out=%b",
               tag, grant, tok_out, eg, et);
    end
  endtask

  // Monitor: pop and compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (grant !== e.g || tok_out !== e.t) begin
          errors++;
          $display("FAIL %s: grant=%b tok_out=%b expected grant=%b tok_out=%b",
                   e.tag, grant, tok_out, e.g, e.t);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    direct(5'b00000, 1'b0, "R1 reset owner");

    // release reset with requests 1 and 2 pending
    rst_n = 1'b1;
    e.g = 5'b00010;
    e.t = 1'b0;
    e.tag = "R2 proc over txdma";
    sb.push_back(e);

    step(5'b00111, 1'b0, 5'b00010, 1'b0, "R3 hold despite rx");
    step(5'b00101, 1'b0, 5'b00001, 1'b0, "R4 move to rx");
    step(5'b10100, 1'b0, 5'b00100, 1'b0, "R4 R2 txdma over refresh");
    step(5'b10000, 1'b0, 5'b10000, 1'b0, "R4 refresh");
    step(5'b00000, 1'b0, 5'b00000, 1'b1, "R8 pulse cycle 1");
    step(5'b11111, 1'b0, 5'b00000, 1'b1, "R6 R8 pulse cycle 2");
    step(5'b11111, 1'b0, 5'b00000, 1'b1, "R6 R8 pulse cycle 3");
    step(5'b11111, 1'b0, 5'b00000, 1'b0, "R8 pulse ends");
    step(5'b11111, 1'b0, 5'b00000, 1'b0, "R6 no token");
    step(5'b11111, 1'b0, 5'b00000, 1'b0, "R6 no token");

    // token arrives with only the interrupt request
    step(5'b01000, 1'b1, 5'b00000, 1'b0, "R7 sync k");
    step(5'b01000, 1'b1, 5'b00000, 1'b0, "R7 sync k+1");
    step(5'b01000, 1'b1, 5'b00000, 1'b0, "R7 owner k+2");
    step(5'b01000, 1'b1, 5'b01000, 1'b0, "R7 grant k+3");
    step(5'b00000, 1'b1, 5'b00000, 1'b1, "R8 release 1");
    step(5'b00000, 1'b1, 5'b00000, 1'b1, "R8 release 2");
    step(5'b00000, 1'b1, 5'b00000, 1'b1, "R8 release 3");
    step(5'b00000, 1'b1, 5'b00000, 1'b0, "R8 release end");
    step(5'b00001, 1'b1, 5'b00000, 1'b0, "R9 level no capture");
    step(5'b00001, 1'b1, 5'b00000, 1'b0, "R9 level no capture");
    step(5'b00001, 1'b1, 5'b00000, 1'b0, "R9 level no capture");

    // new edge, interrupt against refresh
    step(5'b11000, 1'b0, 5'b00000, 1'b0, "R6 low token");
    step(5'b11000, 1'b0, 5'b00000, 1'b0, "R6 low token");
    step(5'b11000, 1'b1, 5'b00000, 1'b0, "R7 second k");
    step(5'b11000, 1'b1, 5'b00000, 1'b0, "R7 second k+1");
    step(5'b11000, 1'b1, 5'b00000, 1'b0, "R7 second k+2");
    step(5'b11000, 1'b1, 5'b01000, 1'b0, "R2 irq over refresh");
    step(5'b10000, 1'b1, 5'b10000, 1'b0, "R4 refresh after irq");
    step(5'b00000, 1'b1, 5'b00000, 1'b1, "R8 pulse again");
    step(5'b00000, 1'b1, 5'b00000, 1'b1, "R8 pulse again");
    step(5'b00000, 1'b1, 5'b00000, 1'b1, "R8 pulse again");
    step(5'b00000, 1'b1, 5'b00000, 1'b0, "R8 pulse done");

    // non-owner strap
    @(negedge clk);
    rst_n = 1'b0;
    start_owner = 1'b0;
    tok_in = 1'b0;
    req = 5'b00001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    direct(5'b00000, 1'b0, "R1 reset non-owner");
    rst_n = 1'b1;
    step(5'b00001, 1'b0, 5'b00000, 1'b0, "R1 non-owner no grant");
    step(5'b00001, 1'b0, 5'b00000, 1'b0, "R1 non-owner no grant");
    step(5'b00001, 1'b0, 5'b00000, 1'b0, "R1 non-owner no grant");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule